// File: doc/BRIEF.md
# Pairwise Floating-Point Min/Max Number Vector Unit

This unit takes two source vectors and returns one vector of floating-point minimum-number or maximum-number results. Lanes can be half, single or double precision, and the vector can be 64 or 128 bits wide.

In pairwise mode the two sources are joined into one double-length vector, with the second source on top. Each adjacent pair of lanes then collapses into one result lane. In elementwise mode, lane e of the first source is compared with lane e of the second.

A quiet NaN set against a number gives the number. Every other NaN case follows the usual scalar min/max rules, and a signalling NaN raises an invalid-operation flag. A request is presented with `in_valid`. The result appears one clock later with `out_valid`, from a single output register stage.

Top module: `fp_pair_minmax`

## Requirements
- R1: With `pair`=1, operands are taken from the concatenation {src_b, src_a}, where src_a is the low half. In 64-bit mode only the low 64 bits of each source are used. Result lane e is the min/max of concatenated lanes 2e and 2e+1.
- R2: With `pair`=0, result lane e is the min/max of lane e of `src_a` and lane e of `src_b`.
- R3: `prec` selects the element size: 0 is 16 bits, 1 is 32 bits, 2 is 64 bits. `wide`=1 selects a 128-bit vector and `wide`=0 a 64-bit vector. The lane count is the vector width divided by the element size, and lane 0 sits in bits [EW-1:0].
- R4: `is_max`=0 returns the minimum and `is_max`=1 returns the maximum. Both use the same NaN rules.
- R5: When exactly one input of a pair is a quiet NaN (quiet bit = top mantissa bit set) and the other is not a NaN, the non-NaN value is returned and no invalid flag is raised for that lane.
- R6: If either input is a signalling NaN, the lane raises invalid. It returns the signalling NaN with its quiet bit set and its payload kept. The first element (src_a side, or the lower lane of the pair) wins when both inputs signal.
- R7: When both inputs are quiet NaNs, the first element is returned unchanged and no invalid flag is raised.
- R8: Minimum orders -0 below +0, and maximum orders +0 above -0.
- R9: Subnormals are compared by value with no flushing, and infinities order beyond every finite value.
- R10: `invalid` is the OR of the per-lane invalid conditions over active lanes only. Data in the upper 64 bits in 64-bit mode cannot set it.
- R11: With `wide`=0, bits [127:64] of the result are zero.
- R12: `prec`=2 with `wide`=0, and `prec`=3, are reserved. Either raises `reserved`, returns an all-zero result and forces `invalid` to 0.
- R13: `out_valid` is `in_valid` delayed by one clock. Result and flags update only on a valid request. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| prec | input | 2 | Element size select |
| wide | input | 1 | 1 = 128-bit vector, 0 = 64-bit |
| pair | input | 1 | 1 = pairwise, 0 = elementwise |
| is_max | input | 1 | 1 = maximum, 0 = minimum |
| out_valid | output | 1 | Result strobe |
| result | output | 128 | Destination vector |
| invalid | output | 1 | Invalid-operation flag |
| reserved | output | 1 | Reserved configuration flag |

## Verification
The assertions assume that `in_valid` is held low during reset. They also assume that the control inputs are stable around the sampling edge, so that a registered flag can be traced back to the request one cycle earlier. The stimulus changes inputs only on falling edges and keeps `in_valid` low until reset is released. Each request deliberately puts NaNs, zeros of both signs or garbage into lanes that must not influence the result, so that stray decoding shows up on the ports.

// File: rtl/fp_pair_minmax.sv
module fp_pair_minmax #(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  input  logic [1:0]    prec,
  input  logic          wide,
  input  logic          pair,
  input  logic          is_max,
  output logic          out_valid,
  output logic [VW-1:0] result,
  output logic          invalid,
  output logic          reserved
);
  localparam int HW = VW / 2;

  logic [2*VW-1:0] cat;
  logic            rsv;
  logic [VW-1:0]   nxt_res;
  logic            nxt_inv;

  assign cat = wide ? {src_b, src_a} : {{VW{1'b0}}, src_b[HW-1:0], src_a[HW-1:0]};
  assign rsv = (prec == 2'd3) || (prec == 2'd2 && !wide);

  for (genvar g = 0; g < 3; g++) begin : pw
    localparam int EW = 16 << g;
    localparam int NL = VW / EW;
    localparam int MB = (EW == 16) ? 10 : (EW == 32) ? 23 : 52;
    logic [VW-1:0] lres;
    logic [NL-1:0] linv;

    for (genvar e = 0; e < NL; e++) begin : ln
      logic [EW-1:0] p, q, kp, kq, o;
      logic act, np, nq, sp, sq, iv;

      assign act = wide || (e < NL / 2);
      assign p = pair ? cat[2*e*EW +: EW]     : src_a[e*EW +: EW];
      assign q = pair ? cat[(2*e+1)*EW +: EW] : src_b[e*EW +: EW];

      always_comb begin
        np = (&p[EW-2:MB]) && (|p[MB-1:0]);
        nq = (&q[EW-2:MB]) && (|q[MB-1:0]);
        sp = np && !p[MB-1];
        sq = nq && !q[MB-1];
        kp = p[EW-1] ? ~p : {1'b1, p[EW-2:0]};
        kq = q[EW-1] ? ~q : {1'b1, q[EW-2:0]};
        iv = sp || sq;
        if (sp)      o = {p[EW-1:MB], 1'b1, p[MB-2:0]};
        else if (sq) o = {q[EW-1:MB], 1'b1, q[MB-2:0]};
        else if (np) o = nq ? p : q;
        else if (nq) o = p;
        else         o = ((kp < kq) ^ is_max) ? p : q;
      end

      assign lres[e*EW +: EW] = act ? o : '0;
      assign linv[e] = act && iv;
    end
  end

  always_comb begin
    nxt_res = '0;
    nxt_inv = 1'b0;
    if (!rsv) begin
      case (prec)
        2'd0:    begin nxt_res = pw[0].lres; nxt_inv = |pw[0].linv; end
        2'd1:    begin nxt_res = pw[1].lres; nxt_inv = |pw[1].linv; end
        default: begin nxt_res = pw[2].lres; nxt_inv = |pw[2].linv; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      invalid   <= 1'b0;
      reserved  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= nxt_res;
        invalid  <= nxt_inv;
        reserved <= rsv;
      end
    end
  end

  // R13
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R13
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R12
  rsv_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prec == 2'd2 && !wide) |=> reserved);
  // R12
  rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && reserved) |-> (result == '0 && !invalid));
  // R11
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide) |=> (result[VW-1:HW] == '0));
endmodule

// File: tb/sim_fp_pair_minmax.sv
module sim_fp_pair_minmax;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [127:0] src_a = '0, src_b = '0;
  logic [1:0] prec = '0;
  logic wide = 1'b0, pair = 1'b0, is_max = 1'b0;
  logic out_valid, invalid, reserved;
  logic [127:0] result;

  typedef struct {
    logic [127:0] r;
    logic         i;
    logic         s;
    string        tag;
  } exp_t;
  exp_t sb[$];

  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fp_pair_minmax u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .prec(prec), .wide(wide), .pair(pair), .is_max(is_max),
    .out_valid(out_valid), .result(result), .invalid(invalid), .reserved(reserved)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [127:0] a, input logic [127:0] b, input logic [1:0] pr,
                       input logic w, input logic pa, input logic mx,
                       input logic [127:0] er, input logic ei, input logic es, input string tag);
    exp_t it;
    @(negedge clk);
    src_a = a; src_b = b; prec = pr; wide = w; pair = pa; is_max = mx;
    in_valid = 1'b1;
    it.r = er; it.i = ei; it.s = es; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    src_a = {128{1'b1}}; src_b = {128{1'b1}};
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R13 unexpected out_valid", {127'b0, out_valid}, 128'b0);
      end else begin
        exp_t it;
        it = sb.pop_front();
        check(result === it.r, {it.tag, " result"}, result, it.r);
        check({invalid, reserved} === {it.i, it.s}, {it.tag, " flags"},
              {126'b0, invalid, reserved}, {126'b0, it.i, it.s});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check({out_valid, invalid, reserved} === 3'b000 && result === '0, "R13 reset",
          {result[124:0], out_valid, invalid, reserved}, 128'b0);
    rst_n = 1'b1;

    // R1 pairwise half, 128-bit, min
    drive(128'h4200_3C00_4000_BC00_3C00_4000_4200_3C00, 128'h4000_4000_4000_4000_4000_4000_4000_0000,
          2'd0, 1, 1, 0, 128'h4000_4000_4000_0000_3C00_BC00_3C00_3C00, 0, 0, "R1 pair half min");
    // R4 same with max
    drive(128'h4200_3C00_4000_BC00_3C00_4000_4200_3C00, 128'h4000_4000_4000_4000_4000_4000_4000_0000,
          2'd0, 1, 1, 1, 128'h4000_4000_4000_4000_4200_4000_4000_4200, 0, 0, "R4 pair half max");
    // R2 elementwise single
    drive(128'h40000000_3F800000_C0000000_3F800000, 128'h3F800000_40000000_3F800000_C0000000,
          2'd1, 1, 0, 0, 128'h3F800000_3F800000_C0000000_C0000000, 0, 0, "R2 elem single min");
    idle();
    // R3 pairwise double
    drive(128'h4000000000000000_3FF0000000000000, 128'hC008000000000000_4000000000000000,
          2'd2, 1, 1, 0, 128'hC008000000000000_3FF0000000000000, 0, 0, "R3 pair double min");
    // R10 R11 narrow pair single, signalling NaNs above the active width
    drive(128'h7F800001_7F800001_40000000_3F800000, 128'h7F800001_7F800001_3F800000_C0000000,
          2'd1, 0, 1, 0, 128'h0_C0000000_3F800000, 0, 0, "R10 R11 narrow pair single");
    // R5 quiet NaN with number
    drive(128'hFFFF_FFFF_FFFF_FFFF_4000_FE00_3C00_7E00, 128'h4000_BC00_7E00_4000,
          2'd0, 0, 0, 0, 128'h4000_BC00_3C00_4000, 0, 0, "R5 qnan vs number");
    // R6 signalling NaN quieted; R9 subnormal and -inf in max
    drive(128'h8001_FC00_0002_0001_7D05_3C00_3C00_7C01, {8{16'h3C00}},
          2'd0, 1, 1, 1, 128'h3C00_3C00_3C00_3C00_8001_0002_7F05_7E01, 1, 0, "R6 R9 snan pair half max");
    // R6 priority between two signalling NaNs
    drive(128'h7FC00000_7F800005, 128'h7F800003_7F800009,
          2'd1, 0, 0, 0, 128'h7FC00003_7FC00005, 1, 0, "R6 snan priority");
    // R7 both quiet NaN
    drive(128'h3FF0000000000000_7FF8000000000011, 128'h4000000000000000_7FF8000000000022,
          2'd2, 1, 0, 0, 128'h3FF0000000000000_7FF8000000000011, 0, 0, "R7 both qnan");
    // R8 signed zeros, min then max
    drive(128'hFC00_7C00_8000_0000, 128'h0001_4000_0000_8000,
          2'd0, 0, 0, 0, 128'hFC00_4000_8000_8000, 0, 0, "R8 zero min");
    drive(128'hFC00_7C00_8000_0000, 128'h0001_4000_0000_8000,
          2'd0, 0, 0, 1, 128'h0001_7C00_0000_0000, 0, 0, "R8 zero max");
    // R9 subnormals and infinity, single max
    drive(128'h00800000_7F800000_80000001_00000001, 128'h007FFFFF_7F7FFFFF_80000002_00000002,
          2'd1, 1, 0, 1, 128'h00800000_7F800000_80000001_00000002, 0, 0, "R9 subnormal max");
    // R12 reserved configurations
    drive(128'h7FF0000000000001_7FF0000000000001, 128'h0, 2'd2, 0, 0, 0, 128'h0, 0, 1, "R12 double narrow");
    drive(128'h7F800001_7F800001_7F800001_7F800001, 128'h0, 2'd3, 1, 1, 0, 128'h0, 0, 1, "R12 prec3");
    idle();
    repeat (3) @(negedge clk);
    // R13 valid drops and scoreboard drained
    check(out_valid === 1'b0, "R13 idle valid", {127'b0, out_valid}, 128'b0);
    check(sb.size() == 0, "R13 drained", 128'(sb.size()), 128'b0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule